// File: doc/BRIEF.md
# Subset Integer Execute Unit

This block runs a narrow slice of a 32-bit, three-format integer instruction set at a rate of one instruction per clock. Each cycle the caller presents a 32-bit instruction word and a valid strobe. The unit splits the word into fields, reads two source operands from a 32-entry general register file, forms the result and writes it back on the same rising edge. Multiply and divide results go into a separate high/low register pair. Two move instructions copy either half of that pair back into a general register.

Loads, stores, control transfer, shifts, traps and pipelining are outside this block. Any encoding the unit does not recognise leaves all state unchanged. A debug select input reads out any general register combinationally, and two further outputs show the high and low halves. A test harness uses these to observe architectural state after every instruction.

Top module: `intx_core`

## Requirements
- R1: After reset, every general register and both halves of the high/low pair read as zero.
- R2: With bits [31:26] equal to 0 (register format: source A in [25:21], source B in [20:16], destination in [15:11], function in [5:0]), function 32 adds, 34 subtracts A minus B, 36 is bitwise AND, 37 is bitwise OR and 42 writes 1 if A is less than B as signed values, else 0. Add and subtract wrap modulo 2^32 with no trap.
- R3: With a nonzero operation code in [31:26], the destination is [20:16] and the 16-bit immediate is [15:0]. Code 8 adds the sign-extended immediate (wrapping), code 10 is a signed less-than against the sign-extended immediate, code 12 ANDs with the zero-extended immediate and code 13 ORs with the zero-extended immediate.
- R4: Register 0 always reads as zero, and any write addressed to it is discarded.
- R5: Function 24 stores the signed 64-bit product of A and B, with the upper word in the high half and the lower word in the low half. No general register is written.
- R6: Function 26 divides A by B as signed values and truncates toward zero. The quotient goes to the low half and the remainder to the high half, and the remainder takes the sign of the dividend. The case 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: A divide whose divisor is zero leaves both halves of the high/low pair unchanged.
- R8: Function 16 copies the high half into the destination register, and function 18 copies the low half.
- R9: Any other operation code, any other function code, and function 8 (register jump) change no general register and neither half of the high/low pair.
- R10: State changes only on a rising clock edge while valid is high. With valid low the word has no effect. A result becomes visible on the debug outputs right after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is to be executed this cycle |
| instr_word | input | 32 | Instruction word |
| dbg_sel | input | 5 | General register index for the debug read |
| dbg_reg | output | 32 | Current value of the selected general register |
| dbg_hi | output | 32 | Current high half of the multiply/divide pair |
| dbg_lo | output | 32 | Current low half of the multiply/divide pair |

## Verification
The corner cases that are hardest to reach are the signed overflow cases: a divide of 0x80000000 by -1, wrapping adds and signed products of large operands. The immediate field carries only 16 bits, so no single instruction can place such values in a register. The stimulus builds them with instructions: it sign-extends 0x8000 into a register, squares it with a multiply, moves the low half out, and doubles that result with an add to reach 0x80000000. From that value it derives 0x7FFFFFFF and -1, then uses them for the overflow, divide-by-zero and large-product checks. A reference model kept alongside the stimulus supplies every expected value.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_ANDI = 6'd12;
  localparam logic [5:0] OPC_ORI  = 6'd13;

  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_MFHI = 6'd16;
  localparam logic [5:0] FN_MFLO = 6'd18;
  localparam logic [5:0] FN_MULT = 6'd24;
  localparam logic [5:0] FN_DIV  = 6'd26;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_SLT  = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_HI, ALU_LO
  } alu_op_e;

  typedef enum logic [1:0] {
    HL_IDLE, HL_MULT, HL_DIV
  } hl_op_e;

  typedef struct packed {
    logic            gpr_we;
    logic [RIDX-1:0] dst;
    alu_op_e         alu_op;
    hl_op_e          hl_op;
    logic            use_imm;
    logic [XLEN-1:0] imm;
  } dec_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext16(input logic [15:0] v);
    return {{(XLEN-16){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] wrap_sub(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a - b;
  endfunction

  function automatic logic [XLEN-1:0] lt_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
  endfunction

  function automatic logic [2*XLEN-1:0] mul_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic signed [2*XLEN-1:0] ea;
    logic signed [2*XLEN-1:0] eb;
    ea = {{XLEN{a[XLEN-1]}}, a};
    eb = {{XLEN{b[XLEN-1]}}, b};
    return ea * eb;
  endfunction

  // Returns {remainder, quotient}; divisor zero yields zero (caller ignores it).
  function automatic logic [2*XLEN-1:0] div_signed(input logic [XLEN-1:0] n, input logic [XLEN-1:0] d);
    logic signed [XLEN-1:0] q;
    logic signed [XLEN-1:0] r;
    if (d == '0) return '0;
    if (n == {1'b1, {(XLEN-1){1'b0}}} && d == '1)
      return {{XLEN{1'b0}}, 1'b1, {(XLEN-1){1'b0}}};
    q = $signed(n) / $signed(d);
    r = $signed(n) % $signed(d);
    return {r, q};
  endfunction
endpackage

// File: rtl/intx_decode.sv
module intx_decode
  import intx_pkg::*;
(
  input  logic            valid,
  input  logic [XLEN-1:0] word,
  output dec_t            dec
);
  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [15:0] imm16;

  assign opc   = word[31:26];
  assign fn    = word[5:0];
  assign imm16 = word[15:0];

  always_comb begin
    dec         = '0;
    dec.alu_op  = ALU_ADD;
    dec.hl_op   = HL_IDLE;
    if (valid) begin
      if (opc == OPC_REG) begin
        dec.dst = word[15:11];
        case (fn)
          FN_ADD:  begin dec.gpr_we = 1'b1; dec.alu_op = ALU_ADD; end
          FN_SUB:  begin dec.gpr_we = 1'b1; dec.alu_op = ALU_SUB; end
          FN_AND:  begin dec.gpr_we = 1'b1; dec.alu_op = ALU_AND; end
          FN_OR:   begin dec.gpr_we = 1'b1; dec.alu_op = ALU_OR;  end
          FN_SLT:  begin dec.gpr_we = 1'b1; dec.alu_op = ALU_SLT; end
          FN_MFHI: begin dec.gpr_we = 1'b1; dec.alu_op = ALU_HI;  end
          FN_MFLO: begin dec.gpr_we = 1'b1; dec.alu_op = ALU_LO;  end
          FN_MULT: dec.hl_op = HL_MULT;
          FN_DIV:  dec.hl_op = HL_DIV;
          default: dec.gpr_we = 1'b0;   // register jump and unknown codes
        endcase
      end else begin
        dec.dst     = word[20:16];
        dec.use_imm = 1'b1;
        case (opc)
          OPC_ADDI: begin dec.gpr_we = 1'b1; dec.alu_op = ALU_ADD; dec.imm = sext16(imm16); end
          OPC_SLTI: begin dec.gpr_we = 1'b1; dec.alu_op = ALU_SLT; dec.imm = sext16(imm16); end
          OPC_ANDI: begin dec.gpr_we = 1'b1; dec.alu_op = ALU_AND; dec.imm = zext16(imm16); end
          OPC_ORI:  begin dec.gpr_we = 1'b1; dec.alu_op = ALU_OR;  dec.imm = zext16(imm16); end
          default:  dec.gpr_we = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/intx_regs.sv
module intx_regs #(
  parameter  int W     = 32,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] rc,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb,
  output logic [W-1:0]  qc
);
  logic [DEPTH-1:0][W-1:0] bank;
  logic                    wr_to_zero;

  assign wr_to_zero = we && (waddr == '0);

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
      if (gi == 0) begin : g_zero
        assign bank[gi] = '0;
      end else begin : g_live
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            q <= '0;
          else if (we && waddr == AW'(gi))
            q <= wdata;
        end
        assign bank[gi] = q;
      end
    end
  endgenerate

  assign qa = bank[ra];
  assign qb = bank[rb];
  assign qc = bank[rc];

  AST_ZERO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_to_zero && ra == '0) |=> (ra != '0 || qa == '0)); // R4
endmodule

// File: rtl/intx_alu.sv
module intx_alu
  import intx_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = wrap_add(a, b);
      ALU_SUB: y = wrap_sub(a, b);
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = lt_signed(a, b);
      ALU_HI:  y = hi;
      ALU_LO:  y = lo;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/intx_hilo.sv
module intx_hilo
  import intx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  hl_op_e          cmd,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] hi,
  output logic [XLEN-1:0] lo
);
  logic [2*XLEN-1:0] prod;
  logic [2*XLEN-1:0] quo_rem;
  logic              div_by_zero;
  logic              div_live;

  assign prod        = mul_signed(a, b);
  assign quo_rem     = div_signed(a, b);
  assign div_by_zero = (cmd == HL_DIV) && (b == '0);
  assign div_live    = (cmd == HL_DIV) && (b != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
    end else begin
      case (cmd)
        HL_MULT: begin
          hi <= prod[2*XLEN-1:XLEN];
          lo <= prod[XLEN-1:0];
        end
        HL_DIV: begin
          if (div_live) begin
            hi <= quo_rem[2*XLEN-1:XLEN];
            lo <= quo_rem[XLEN-1:0];
          end
        end
        default: begin
        end
      endcase
    end
  end

  AST_DIVZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |=> ($stable(hi) && $stable(lo))); // R7
  AST_HILO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == HL_IDLE) |=> ($stable(hi) && $stable(lo))); // R9
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    div_live |=> (hi == '0 || hi[XLEN-1] == $past(a[XLEN-1]))); // R6
endmodule

// File: rtl/intx_core.sv
module intx_core
  import intx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [31:0] instr_word,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_reg,
  output logic [31:0] dbg_hi,
  output logic [31:0] dbg_lo
);
  dec_t            dec;
  logic [RIDX-1:0] src_a;
  logic [RIDX-1:0] src_b;
  logic [XLEN-1:0] a_val;
  logic [XLEN-1:0] b_reg;
  logic [XLEN-1:0] b_val;
  logic [XLEN-1:0] hi_q;
  logic [XLEN-1:0] lo_q;
  logic [XLEN-1:0] result;
  logic            gpr_write_ev;
  logic            hilo_cmd_ev;
  logic            is_reg_fmt;

  assign src_a        = instr_word[25:21];
  assign src_b        = instr_word[20:16];
  assign is_reg_fmt   = (instr_word[31:26] == OPC_REG);
  assign gpr_write_ev = dec.gpr_we;
  assign hilo_cmd_ev  = (dec.hl_op != HL_IDLE);

  intx_decode u_dec (
    .valid (instr_valid),
    .word  (instr_word),
    .dec   (dec)
  );

  intx_regs #(.W(XLEN), .DEPTH(NREG)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dec.gpr_we),
    .waddr (dec.dst),
    .wdata (result),
    .ra    (src_a),
    .rb    (src_b),
    .rc    (dbg_sel),
    .qa    (a_val),
    .qb    (b_reg),
    .qc    (dbg_reg)
  );

  assign b_val = dec.use_imm ? dec.imm : b_reg;

  intx_alu u_alu (
    .op (dec.alu_op),
    .a  (a_val),
    .b  (b_val),
    .hi (hi_q),
    .lo (lo_q),
    .y  (result)
  );

  intx_hilo u_hilo (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (dec.hl_op),
    .a     (a_val),
    .b     (b_reg),
    .hi    (hi_q),
    .lo    (lo_q)
  );

  assign dbg_hi = hi_q;
  assign dbg_lo = lo_q;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!gpr_write_ev && !hilo_cmd_ev)); // R10
  AST_REG_FMT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_write_ev && is_reg_fmt) |-> (dec.dst == instr_word[15:11])); // R2
  AST_IMM_FMT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_write_ev && !is_reg_fmt) |-> (dec.dst == instr_word[20:16])); // R3
  AST_HILO_NO_GPR: assert property (@(posedge clk) disable iff (!rst_n)
    hilo_cmd_ev |-> !gpr_write_ev); // R5
endmodule

// File: tb/intx_core_bench.sv
module intx_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [4:0]  dbg_sel = '0;
  wire  [31:0] dbg_reg;
  wire  [31:0] dbg_hi;
  wire  [31:0] dbg_lo;

  always #10 clk = ~clk;   // 50 MHz

  intx_core u_intx_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .dbg_sel     (dbg_sel),
    .dbg_reg     (dbg_reg),
    .dbg_hi      (dbg_hi),
    .dbg_lo      (dbg_lo)
  );

  typedef struct {
    bit          is_hl;
    int          addr;
    logic [31:0] e0;
    logic [31:0] e1;
    string       req;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;
  bit   [31:0] m[32];
  bit   [31:0] mhi = '0;
  bit   [31:0] mlo = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per edge and compares shortly after it.
  always begin
    @(posedge clk);
    if (sbq.size() > 0) begin
      item_t it;
      #5;
      it = sbq.pop_front();
      if (it.is_hl) begin
        chk({it.req, " hi"}, dbg_hi, it.e0);
        chk({it.req, " lo"}, dbg_lo, it.e1);
      end else begin
        chk(it.req, dbg_reg, it.e0);
      end
    end
  end

  function automatic logic [31:0] enc_r(input int fn, input int rs, input int rt, input int rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic push_reg(input logic [31:0] w, input int r, input string req, input bit v);
    item_t it;
    it.is_hl = 0; it.addr = r; it.e0 = m[r]; it.e1 = '0; it.req = req;
    @(negedge clk);
    instr_valid = v; instr_word = w; dbg_sel = 5'(r);
    sbq.push_back(it);
  endtask

  task automatic push_hl(input logic [31:0] w, input string req);
    item_t it;
    it.is_hl = 1; it.addr = 0; it.e0 = mhi; it.e1 = mlo; it.req = req;
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    sbq.push_back(it);
  endtask

  task automatic do_r(input int fn, input int rs, input int rt, input int rd, input string req);
    bit [31:0] a, b, v;
    bit        wr;
    longint    sa, sb, p;
    int        q, r;
    a = m[rs]; b = m[rt]; wr = 1; v = '0;
    case (fn)
      32: v = a + b;
      34: v = a + ~b + 32'd1;
      36: v = a & b;
      37: v = a | b;
      42: v = ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000)) ? 32'd1 : 32'd0;
      16: v = mhi;
      18: v = mlo;
      24: begin
        sa = longint'(signed'(a)); sb = longint'(signed'(b)); p = sa * sb;
        mhi = p[63:32]; mlo = p[31:0];
        push_hl(enc_r(fn, rs, rt, rd), req);
        return;
      end
      26: begin
        if (b != 0) begin
          if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            mlo = 32'h8000_0000; mhi = 32'h0;
          end else begin
            q = int'(signed'(a)) / int'(signed'(b));
            r = int'(signed'(a)) - q * int'(signed'(b));
            mlo = q; mhi = r;
          end
        end
        push_hl(enc_r(fn, rs, rt, rd), req);
        return;
      end
      default: wr = 0;
    endcase
    if (wr && rd != 0) m[rd] = v;
    push_reg(enc_r(fn, rs, rt, rd), rd, req, 1'b1);
  endtask

  task automatic do_i(input int op, input int rs, input int rt, input logic [15:0] imm, input string req);
    bit [31:0] a, se, ze, v;
    bit        wr;
    a = m[rs]; se = {{16{imm[15]}}, imm}; ze = {16'h0, imm}; wr = 1; v = '0;
    case (op)
      8:  v = a + se;
      10: v = ((a ^ 32'h8000_0000) < (se ^ 32'h8000_0000)) ? 32'd1 : 32'd0;
      12: v = a & ze;
      13: v = a | ze;
      default: wr = 0;
    endcase
    if (wr && rt != 0) m[rt] = v;
    push_reg(enc_i(op, rs, rt, imm), rt, req, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 32; i++) begin
      dbg_sel = 5'(i); #1;
      chk("R1 reset reg", dbg_reg, 32'h0);
    end
    chk("R1 reset hi", dbg_hi, 32'h0);
    chk("R1 reset lo", dbg_lo, 32'h0);

    // R3 immediate format
    do_i(8, 0, 1, 16'h0005, "R3 addi");
    do_i(8, 0, 2, 16'hFFFD, "R3 addi sext");
    do_i(13, 0, 3, 16'h8001, "R3 ori zext");
    do_i(12, 2, 4, 16'hFF0F, "R3 andi zext");
    do_i(10, 2, 5, 16'h0001, "R3 slti true");
    do_i(10, 1, 6, 16'hFFFF, "R3 slti false");
    // R2 register format
    do_r(32, 1, 2, 7, "R2 add");
    do_r(34, 2, 1, 8, "R2 sub");
    do_r(36, 3, 4, 9, "R2 and");
    do_r(37, 3, 4, 10, "R2 or");
    do_r(42, 8, 1, 11, "R2 slt true");
    do_r(42, 1, 8, 12, "R2 slt false");
    // R4 register zero
    do_i(8, 1, 0, 16'h0007, "R4 addi to r0");
    do_r(32, 1, 1, 0, "R4 add to r0");
    do_r(32, 0, 1, 13, "R4 r0 source");
    // R5 multiply, rd field 7 must not be written
    do_r(24, 2, 1, 7, "R5 mult small");
    do_r(32, 7, 0, 15, "R5 rd untouched");
    do_r(18, 0, 0, 14, "R8 mflo");
    do_r(16, 0, 0, 15, "R8 mfhi");
    // build 0x80000000 and friends
    do_i(8, 0, 16, 16'h8000, "R3 addi neg");
    do_r(24, 16, 16, 0, "R5 mult square");
    do_r(18, 0, 0, 17, "R8 mflo big");
    do_r(32, 17, 17, 18, "R2 add to msb");
    do_r(32, 18, 18, 19, "R2 add wrap");
    do_r(34, 0, 18, 20, "R2 sub wrap");
    do_i(8, 18, 21, 16'hFFFF, "R3 addi wrap down");
    do_i(8, 21, 22, 16'h0001, "R3 addi wrap up");
    do_i(8, 0, 23, 16'hFFFF, "R3 minus one");
    do_r(24, 21, 21, 0, "R5 mult max");
    do_r(24, 18, 2, 0, "R5 mult min by neg");
    // R6 divide
    do_r(26, 8, 2, 0, "R6 div neg neg");
    do_r(26, 1, 2, 0, "R6 div pos neg");
    do_r(26, 8, 1, 0, "R6 div neg pos");
    do_r(16, 0, 0, 24, "R8 mfhi after div");
    do_r(26, 18, 23, 0, "R6 div overflow");
    // R7 divide by zero
    do_r(26, 1, 0, 0, "R7 div by r0");
    do_r(26, 22, 19, 0, "R7 div by zero reg");
    // R9 ignored encodings
    do_i(63, 1, 25, 16'h1234, "R9 unknown op");
    do_r(0, 1, 1, 26, "R9 unknown funct");
    do_r(8, 1, 0, 27, "R9 register jump");
    do_r(19, 1, 1, 28, "R9 funct 19");
    do_r(18, 0, 0, 29, "R9 hilo kept");
    // R10 valid low: addi r1,r1,1 must not land
    push_reg(enc_i(8, 1, 1, 16'h0001), 1, "R10 idle", 1'b0);
    push_reg(enc_r(24, 1, 1, 0), 1, "R10 idle mult", 1'b0);
    do_r(16, 0, 0, 30, "R10 hi after idle");

    @(negedge clk);
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule